// File: doc/BRIEF.md
# UART Interrupt Source and Priority Logic

This block holds the register-interface portion of a 16550-style serial controller that decides which interrupt to raise. It keeps the interrupt enable, modem control and scratch registers. It reports sticky line-error and modem-change status. It presents one identification byte that names the most urgent pending cause. The receive path, the transmit path and the modem pins supply events and levels. The block combines them with the enable bits. It drives one interrupt line, which is gated by a modem control bit.

Each cause is cleared by its own access side effect, as host software expects:
- Line errors are dropped by reading the line status register.
- Modem deltas are dropped by reading the modem status register.
- The transmit-empty cause is dropped by a transmit write, or by an identification read that reports it.
- Receive data follows the receive path's level.

A loopback mode routes the modem control outputs back into the modem status register, so software can check that the device is present.

Register map (byte addresses on a 3-bit bus): 0 data, 1 enable, 2 identification (read), 3 unused (reads 0), 4 modem control, 5 line status, 6 modem status, 7 scratch.

Top module: `uart_irq_core`

## Requirements
- R1: After reset the enable and modem control registers read 0x00, the identification register reads 0x01, and `irq_o` and `modem_ctl_o` are low.
- R2: Address 7 stores any written byte and returns it on read, for example 0x55 and 0xAA.
- R3: The identification byte is 0x01 when nothing is pending. Otherwise bit 0 is 0 and bits 2:1 give the cause: 0x06 line error, 0x04 receive data, 0x02 transmit empty, 0x00 modem change.
- R4: With several causes pending, the reported cause follows this order: line error, then receive data, then transmit empty, then modem change.
- R5: The line status byte has the following bits:
  - bit 0: `rx_avail_i`
  - bits 1 to 4: sticky overrun, parity, framing and break (from `line_err_i` bits 0 to 3)
  - bit 5: `tx_empty_i`
  - bit 6: `tx_idle_i`
  - bit 7: 0

  The sticky bits clear on a line status read.
- R6: The receive cause follows `rx_avail_i` as a level. Reading address 0 returns `rx_byte_i` and does not clear the cause.
- R7: The transmit-empty cause sets on a rising edge of `tx_empty_i`. It also sets when enable bit 1 is written from 0 to 1 while `tx_empty_i` is high. It clears on a write to address 0, or on an identification read that reports 0x02. An identification read that reports another cause leaves it pending.
- R8: Enable bits gate the causes: bit 0 receive, bit 1 transmit empty, bit 2 line error, bit 3 modem change. A disabled cause neither interrupts nor appears in the identification byte, but its status bits still record.
- R9: The modem status byte has two nibbles:
  - bits 7:4: current DCD, RI, DSR, CTS (`modem_st_i` bits 3..0 map to 7..4)
  - bits 3:0: delta DCD, RI falling edge, delta DSR, delta CTS

  The deltas clear on a modem status read.
- R10: Modem control bit 4 selects loopback. In loopback CTS follows bit 1, DSR follows bit 0, RI follows bit 2 and DCD follows bit 3. `modem_st_i` is ignored and `modem_ctl_o` is 0. After writing 0x1F, a second status read returns 0xF0.
- R11: `irq_o` is high exactly when an enabled cause is pending and modem control bit 3 is set.
- R12: Outside loopback, `modem_ctl_o` equals modem control bits 3:0 (bit 0 DTR, bit 1 RTS, bit 2 OUT1, bit 3 OUT2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | 3 | Register address |
| rd_i | input | 1 | Read strobe, one cycle per access |
| wr_i | input | 1 | Write strobe, one cycle per access |
| wdata_i | input | DW | Write data |
| rdata_o | output | DW | Read data, valid while `rd_i` is high |
| rx_byte_i | input | DW | Byte at the head of the receive path |
| rx_avail_i | input | 1 | Receive data available level |
| line_err_i | input | 4 | Error pulses: overrun, parity, framing, break |
| tx_empty_i | input | 1 | Transmit holding register empty level |
| tx_idle_i | input | 1 | Transmitter fully idle level |
| modem_st_i | input | 4 | Modem inputs {DCD, RI, DSR, CTS} |
| modem_ctl_o | output | 4 | Modem outputs {OUT2, OUT1, RTS, DTR} |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench sets up all four causes at once and walks them down by their own clearing accesses. If the priority were wrong, the wrong code would show first. If a clear were mis-targeted, a cause would disappear too early or stay stuck.

The transmit-empty cause is probed from three directions:
- an identification read that reports a different cause, which must not clear it;
- a rising edge of the enable bit, which must set it;
- a transmit write, which must clear it.

A wrong rule here either loses transmit interrupts or repeats them forever.

Loopback is probed with the presence test and with partial patterns. These catch swapped DTR and RTS routing, external pins leaking through, and a ring-indicator delta that fires on the wrong edge.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

  localparam int ADDR_W = 3;
  localparam int NCAUSE = 4;

  typedef enum logic [ADDR_W-1:0] {
    A_DATA = 3'd0,
    A_IEN  = 3'd1,
    A_IDENT = 3'd2,
    A_RSVD = 3'd3,
    A_MCTL = 3'd4,
    A_LSTAT = 3'd5,
    A_MSTAT = 3'd6,
    A_SCR  = 3'd7
  } reg_addr_e;

  // Cause code, also the request index: higher value wins
  typedef enum logic [1:0] {
    CID_MODEM = 2'b00,
    CID_THRE  = 2'b01,
    CID_RXD   = 2'b10,
    CID_LINE  = 2'b11
  } cause_e;

endpackage

// File: rtl/uart_irq_lsr.sv
module uart_irq_lsr #(
  parameter int NERR = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NERR-1:0] err_i,
  input  logic            clr_i,
  output logic [NERR-1:0] sticky_o
);

  logic [NERR-1:0] sticky_q, sticky_d;

  always_comb begin
    sticky_d = (clr_i ? '0 : sticky_q) | err_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sticky_q <= '0;
    else        sticky_q <= sticky_d;
  end

  assign sticky_o = sticky_q;

endmodule

// File: rtl/uart_irq_msr.sv
module uart_irq_msr #(
  parameter int NLINE = 4,
  parameter int RI_IDX = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NLINE-1:0] ext_i,
  input  logic [NLINE-1:0] lb_i,
  input  logic             loop_i,
  input  logic             clr_i,
  output logic [NLINE-1:0] now_o,
  output logic [NLINE-1:0] prev_o,
  output logic [NLINE-1:0] delta_o
);

  logic [NLINE-1:0] prev_q, delta_q, delta_d, edge_w, now_w;

  assign now_w = loop_i ? lb_i : ext_i;

  for (genvar i = 0; i < NLINE; i++) begin : g_edge
    if (i == RI_IDX) begin : g_trail
      assign edge_w[i] = prev_q[i] & ~now_w[i];
    end else begin : g_any
      assign edge_w[i] = prev_q[i] ^ now_w[i];
    end
  end

  always_comb begin
    delta_d = (clr_i ? '0 : delta_q) | edge_w;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= '0;
      delta_q <= '0;
    end else begin
      prev_q  <= now_w;
      delta_q <= delta_d;
    end
  end

  assign now_o   = now_w;
  assign prev_o  = prev_q;
  assign delta_o = delta_q;

endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
  import uart_irq_pkg::*;
#(
  parameter int N = NCAUSE
) (
  input  logic [N-1:0] req_i,
  output logic         any_o,
  output cause_e       cid_o
);

  always_comb begin
    cid_o = CID_MODEM;
    for (int i = 0; i < N; i++) begin
      if (req_i[i]) cid_o = cause_e'(i);
    end
    any_o = |req_i;
  end

endmodule

// File: rtl/uart_irq_core.sv
module uart_irq_core
  import uart_irq_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  input  logic [DW-1:0]     rx_byte_i,
  input  logic              rx_avail_i,
  input  logic [3:0]        line_err_i,
  input  logic              tx_empty_i,
  input  logic              tx_idle_i,
  input  logic [3:0]        modem_st_i,
  output logic [3:0]        modem_ctl_o,
  output logic              irq_o
);

  localparam int MCW = 5;
  localparam int PAD = DW - 8;

  // Reset: asserted at once, released through two flops
  logic [1:0] rs_q;
  logic       rst_s_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_s_n = rs_q[1];

  // Access decode
  logic wr_data, wr_ien, wr_mctl, wr_scr, rd_ident, rd_lstat, rd_mstat;
  assign wr_data  = wr_i & (addr_i == A_DATA);
  assign wr_ien   = wr_i & (addr_i == A_IEN);
  assign wr_mctl  = wr_i & (addr_i == A_MCTL);
  assign wr_scr   = wr_i & (addr_i == A_SCR);
  assign rd_ident = rd_i & (addr_i == A_IDENT);
  assign rd_lstat = rd_i & (addr_i == A_LSTAT);
  assign rd_mstat = rd_i & (addr_i == A_MSTAT);

  // Registers
  logic [NCAUSE-1:0] ier_q, ier_d;
  logic [MCW-1:0]    mcr_q, mcr_d;
  logic [DW-1:0]     scr_q, scr_d;
  logic              thre_q, thre_d, txe_prev_q;

  logic [3:0]   lsr_err;
  logic [3:0]   msr_now, msr_prev, msr_delta, lb_vec;
  logic [NCAUSE-1:0] req;
  logic         int_any;
  cause_e       cid;

  uart_irq_lsr #(.NERR(4)) u_lsr (
    .clk(clk), .rst_n(rst_s_n), .err_i(line_err_i),
    .clr_i(rd_lstat), .sticky_o(lsr_err)
  );

  // Loopback map {DCD,RI,DSR,CTS} <- {OUT2,OUT1,DTR,RTS}
  assign lb_vec = {mcr_q[3], mcr_q[2], mcr_q[0], mcr_q[1]};

  uart_irq_msr #(.NLINE(4), .RI_IDX(2)) u_msr (
    .clk(clk), .rst_n(rst_s_n), .ext_i(modem_st_i), .lb_i(lb_vec),
    .loop_i(mcr_q[4]), .clr_i(rd_mstat), .now_o(msr_now),
    .prev_o(msr_prev), .delta_o(msr_delta)
  );

  assign req[CID_LINE]  = ier_q[2] & (|lsr_err);
  assign req[CID_RXD]   = ier_q[0] & rx_avail_i;
  assign req[CID_THRE]  = ier_q[1] & thre_q;
  assign req[CID_MODEM] = ier_q[3] & (|msr_delta);

  uart_irq_prio #(.N(NCAUSE)) u_prio (
    .req_i(req), .any_o(int_any), .cid_o(cid)
  );

  // Next state
  logic thre_set, thre_clr;
  always_comb begin
    ier_d = wr_ien  ? wdata_i[NCAUSE-1:0] : ier_q;
    mcr_d = wr_mctl ? wdata_i[MCW-1:0]    : mcr_q;
    scr_d = wr_scr  ? wdata_i             : scr_q;
    thre_set = (tx_empty_i & ~txe_prev_q)
             | (wr_ien & wdata_i[1] & ~ier_q[1] & tx_empty_i);
    thre_clr = wr_data | (rd_ident & int_any & (cid == CID_THRE));
    thre_d   = thre_clr ? 1'b0 : (thre_q | thre_set);
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      ier_q      <= '0;
      mcr_q      <= '0;
      scr_q      <= '0;
      thre_q     <= 1'b0;
      txe_prev_q <= 1'b0;
    end else begin
      ier_q      <= ier_d;
      mcr_q      <= mcr_d;
      scr_q      <= scr_d;
      thre_q     <= thre_d;
      txe_prev_q <= tx_empty_i;
    end
  end

  // Read mux
  logic [7:0] rd8;
  always_comb begin
    rd8 = 8'h00;
    unique case (reg_addr_e'(addr_i))
      A_DATA:  rd8 = rx_byte_i[7:0];
      A_IEN:   rd8 = {4'h0, ier_q};
      A_IDENT: rd8 = {5'b0, cid, ~int_any};
      A_RSVD:  rd8 = 8'h00;
      A_MCTL:  rd8 = {3'b0, mcr_q};
      A_LSTAT: rd8 = {1'b0, tx_idle_i, tx_empty_i, lsr_err, rx_avail_i};
      A_MSTAT: rd8 = {msr_now, msr_delta};
      A_SCR:   rd8 = scr_q[7:0];
      default: rd8 = 8'h00;
    endcase
  end

  generate
    if (PAD > 0) begin : g_wide
      always_comb begin
        rdata_o = {{PAD{1'b0}}, rd8};
        if (addr_i == A_SCR)  rdata_o = scr_q;
        if (addr_i == A_DATA) rdata_o = rx_byte_i;
      end
    end else begin : g_byte
      assign rdata_o = rd8;
    end
  endgenerate

  assign irq_o       = int_any & mcr_q[3];
  assign modem_ctl_o = mcr_q[4] ? 4'h0 : mcr_q[3:0];

endmodule

// File: rtl/uart_irq_core_chk.sv
module uart_irq_core_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_s_n,
  input logic [2:0]    addr_i,
  input logic          rd_i,
  input logic          wr_i,
  input logic [DW-1:0] rdata_o,
  input logic          irq_o,
  input logic [4:0]    mcr_q,
  input logic [3:0]    ier_q,
  input logic [3:0]    lsr_err,
  input logic [3:0]    line_err_i,
  input logic          thre_q,
  input logic          int_any,
  input logic [3:0]    msr_now,
  input logic [3:0]    msr_prev,
  input logic [3:0]    msr_delta,
  input logic [3:0]    modem_ctl_o
);

  AST_IDENT_IDLE: assert property (@(posedge clk) disable iff (!rst_s_n)
    (rd_i && addr_i == 3'd2 && !int_any) |-> rdata_o[7:0] == 8'h01); // R3

  AST_LINE_FIRST: assert property (@(posedge clk) disable iff (!rst_s_n)
    (rd_i && addr_i == 3'd2 && ier_q[2] && lsr_err != 4'h0) |-> rdata_o[3:0] == 4'h6); // R4

  AST_LSTAT_CLEARS: assert property (@(posedge clk) disable iff (!rst_s_n)
    (rd_i && addr_i == 3'd5 && line_err_i == 4'h0) |=> lsr_err == 4'h0); // R5

  AST_TXWR_CLEARS: assert property (@(posedge clk) disable iff (!rst_s_n)
    (wr_i && addr_i == 3'd0) |=> !thre_q); // R7

  AST_MSTAT_CLEARS: assert property (@(posedge clk) disable iff (!rst_s_n)
    (rd_i && addr_i == 3'd6 && msr_now == msr_prev) |=> msr_delta == 4'h0); // R9

  AST_LOOP_QUIET: assert property (@(posedge clk) disable iff (!rst_s_n)
    mcr_q[4] |-> modem_ctl_o == 4'h0); // R10

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_s_n)
    !mcr_q[3] |-> !irq_o); // R11

endmodule

bind uart_irq_core uart_irq_core_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_s_n(rst_s_n), .addr_i(addr_i), .rd_i(rd_i), .wr_i(wr_i),
  .rdata_o(rdata_o), .irq_o(irq_o), .mcr_q(mcr_q), .ier_q(ier_q),
  .lsr_err(lsr_err), .line_err_i(line_err_i), .thre_q(thre_q),
  .int_any(int_any), .msr_now(msr_now), .msr_prev(msr_prev),
  .msr_delta(msr_delta), .modem_ctl_o(modem_ctl_o)
);

// File: tb/uart_irq_core_test.sv
module uart_irq_core_test;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] addr_i;
  logic       rd_i, wr_i;
  logic [7:0] wdata_i, rdata_o, rx_byte_i;
  logic       rx_avail_i, tx_empty_i, tx_idle_i, irq_o;
  logic [3:0] line_err_i, modem_st_i, modem_ctl_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  uart_irq_core #(.DW(8)) uut (
    .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .rd_i(rd_i), .wr_i(wr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .rx_byte_i(rx_byte_i),
    .rx_avail_i(rx_avail_i), .line_err_i(line_err_i), .tx_empty_i(tx_empty_i),
    .tx_idle_i(tx_idle_i), .modem_st_i(modem_st_i), .modem_ctl_o(modem_ctl_o),
    .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    addr_i = a; wdata_i = d; wr_i = 1'b1;
    @(negedge clk);
    wr_i = 1'b0;
  endtask

  task automatic bus_rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    addr_i = a; rd_i = 1'b1;
    #1 d = rdata_o;
    @(negedge clk);
    rd_i = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [2:0] a, input logic [7:0] exp);
    logic [7:0] v;
    bus_rd(a, v);
    chk(req, v, exp);
  endtask

  task automatic err_pulse(input logic [3:0] e);
    @(negedge clk);
    line_err_i = e;
    @(negedge clk);
    line_err_i = 4'h0;
  endtask

  task automatic t_reset;
    rd_chk("R1 ident", 3'd2, 8'h01);
    rd_chk("R1 ien", 3'd1, 8'h00);
    rd_chk("R1 mctl", 3'd4, 8'h00);
    chk("R1 irq", {7'b0, irq_o}, 8'h00);
    chk("R1 modem_ctl", {4'b0, modem_ctl_o}, 8'h00);
  endtask

  task automatic t_scratch;
    bus_wr(3'd7, 8'h55);
    rd_chk("R2 scratch 55", 3'd7, 8'h55);
    bus_wr(3'd7, 8'hAA);
    rd_chk("R2 scratch AA", 3'd7, 8'hAA);
  endtask

  task automatic t_line;
    bus_wr(3'd1, 8'h04);
    bus_wr(3'd4, 8'h08);
    err_pulse(4'b0010);
    chk("R5 irq after parity", {7'b0, irq_o}, 8'h01);
    rd_chk("R3 line code", 3'd2, 8'h06);
    rd_chk("R5 lstat parity", 3'd5, 8'h64);
    rd_chk("R5 lstat cleared", 3'd5, 8'h60);
    rd_chk("R3 idle after line", 3'd2, 8'h01);
  endtask

  task automatic t_rx;
    bus_wr(3'd1, 8'h01);
    @(negedge clk);
    rx_byte_i = 8'h3C; rx_avail_i = 1'b1;
    rd_chk("R3 rx code", 3'd2, 8'h04);
    rd_chk("R5 lstat data ready", 3'd5, 8'h61);
    rd_chk("R6 rx byte", 3'd0, 8'h3C);
    rd_chk("R6 rx stays", 3'd2, 8'h04);
    @(negedge clk);
    rx_avail_i = 1'b0;
    rd_chk("R6 rx gone", 3'd2, 8'h01);
  endtask

  task automatic t_thre;
    bus_wr(3'd1, 8'h00);
    @(negedge clk);
    tx_empty_i = 1'b0;
    idle(2);
    bus_wr(3'd0, 8'h11);
    bus_wr(3'd1, 8'h02);
    rd_chk("R7 not empty", 3'd2, 8'h01);
    @(negedge clk);
    tx_empty_i = 1'b1;
    idle(1);
    rd_chk("R7 edge sets", 3'd2, 8'h02);
    rd_chk("R7 ident read clears", 3'd2, 8'h01);
    bus_wr(3'd1, 8'h00);
    bus_wr(3'd1, 8'h02);
    rd_chk("R7 enable sets", 3'd2, 8'h02);
    bus_wr(3'd0, 8'h22);
    rd_chk("R7 tx write clears", 3'd2, 8'h01);
    bus_wr(3'd1, 8'h01);
    bus_wr(3'd1, 8'h03);
    @(negedge clk);
    rx_avail_i = 1'b1;
    rd_chk("R7 rx reported", 3'd2, 8'h04);
    @(negedge clk);
    rx_avail_i = 1'b0;
    rd_chk("R7 kept pending", 3'd2, 8'h02);
    bus_wr(3'd0, 8'h33);
  endtask

  task automatic t_prio;
    bus_wr(3'd4, 8'h08);
    bus_wr(3'd1, 8'h0D);
    bus_wr(3'd1, 8'h0F);
    @(negedge clk);
    rx_avail_i = 1'b1; modem_st_i = 4'b0001;
    err_pulse(4'b0001);
    rd_chk("R4 line first", 3'd2, 8'h06);
    rd_chk("R5 lstat overrun", 3'd5, 8'h63);
    rd_chk("R4 rx second", 3'd2, 8'h04);
    @(negedge clk);
    rx_avail_i = 1'b0;
    rd_chk("R4 thre third", 3'd2, 8'h02);
    rd_chk("R4 modem last", 3'd2, 8'h00);
    rd_chk("R9 cts delta", 3'd6, 8'h11);
    rd_chk("R4 all served", 3'd2, 8'h01);
    chk("R11 irq low when idle", {7'b0, irq_o}, 8'h00);
    @(negedge clk);
    modem_st_i = 4'b0000;
    idle(1);
    rd_chk("R9 cts drop delta", 3'd6, 8'h01);
  endtask

  task automatic t_gate;
    bus_wr(3'd1, 8'h00);
    err_pulse(4'b1000);
    chk("R8 no irq disabled", {7'b0, irq_o}, 8'h00);
    rd_chk("R8 ident hides", 3'd2, 8'h01);
    rd_chk("R8 break recorded", 3'd5, 8'h70);
    @(negedge clk);
    modem_st_i = 4'b0010;
    idle(1);
    rd_chk("R8 ident hides modem", 3'd2, 8'h01);
    rd_chk("R8 dsr recorded", 3'd6, 8'h22);
    @(negedge clk);
    modem_st_i = 4'b0000;
    idle(1);
    rd_chk("R9 dsr drop", 3'd6, 8'h02);
  endtask

  task automatic t_modem;
    bus_wr(3'd1, 8'h08);
    @(negedge clk);
    modem_st_i = 4'b0100;
    idle(1);
    rd_chk("R9 ri rise no delta", 3'd6, 8'h40);
    @(negedge clk);
    modem_st_i = 4'b0000;
    idle(1);
    rd_chk("R3 modem code", 3'd2, 8'h00);
    rd_chk("R9 ri trailing", 3'd6, 8'h04);
    rd_chk("R9 cleared", 3'd6, 8'h00);
    @(negedge clk);
    modem_st_i = 4'b1010;
    idle(1);
    rd_chk("R9 dcd dsr", 3'd6, 8'hAA);
    @(negedge clk);
    modem_st_i = 4'b0000;
    idle(1);
    rd_chk("R9 dcd dsr drop", 3'd6, 8'h0A);
  endtask

  task automatic t_loop;
    logic [7:0] v;
    bus_wr(3'd1, 8'h00);
    bus_wr(3'd4, 8'h1F);
    idle(1);
    rd_chk("R10 first read", 3'd6, 8'hFB);
    bus_rd(3'd6, v);
    chk("R10 second read", v, 8'hF0);
    chk("R10 probe mask", v & 8'h3F, 8'h30);
    chk("R10 outputs quiet", {4'b0, modem_ctl_o}, 8'h00);
    @(negedge clk);
    modem_st_i = 4'b0101;
    idle(1);
    rd_chk("R10 pins ignored", 3'd6, 8'hF0);
    @(negedge clk);
    modem_st_i = 4'b0000;
    bus_wr(3'd4, 8'h11);
    idle(1);
    rd_chk("R10 dtr only", 3'd6, 8'h2D);
    rd_chk("R10 dtr settled", 3'd6, 8'h20);
    bus_wr(3'd4, 8'h00);
    idle(1);
    rd_chk("R10 leave loop", 3'd6, 8'h02);
  endtask

  task automatic t_out2;
    bus_wr(3'd1, 8'h01);
    bus_wr(3'd4, 8'h00);
    @(negedge clk);
    rx_avail_i = 1'b1;
    idle(1);
    chk("R11 gated off", {7'b0, irq_o}, 8'h00);
    rd_chk("R11 still pending", 3'd2, 8'h04);
    bus_wr(3'd4, 8'h08);
    idle(1);
    chk("R11 gated on", {7'b0, irq_o}, 8'h01);
    @(negedge clk);
    rx_avail_i = 1'b0;
    #1 chk("R11 drops", {7'b0, irq_o}, 8'h00);
  endtask

  task automatic t_ctl;
    bus_wr(3'd4, 8'h05);
    idle(1);
    chk("R12 dtr out1", {4'b0, modem_ctl_o}, 8'h05);
    bus_wr(3'd4, 8'h0A);
    idle(1);
    chk("R12 rts out2", {4'b0, modem_ctl_o}, 8'h0A);
    bus_wr(3'd4, 8'h1A);
    idle(1);
    chk("R10 loop masks", {4'b0, modem_ctl_o}, 8'h00);
    bus_wr(3'd4, 8'h00);
  endtask

  initial begin
    rst_n = 1'b0; addr_i = '0; rd_i = 1'b0; wr_i = 1'b0; wdata_i = '0;
    rx_byte_i = '0; rx_avail_i = 1'b0; line_err_i = '0;
    tx_empty_i = 1'b1; tx_idle_i = 1'b1; modem_st_i = '0;
    idle(4);
    rst_n = 1'b1;
    idle(4);
    t_reset;
    t_scratch;
    t_line;
    t_rx;
    t_thre;
    t_prio;
    t_gate;
    t_modem;
    t_loop;
    t_out2;
    t_ctl;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule